// File: doc/BRIEF.md
# Paging Control Register Unit

This block keeps the paging-related control state of a 32-bit core: the machine-control word (CR0), the page-table base (CR3), the extension-control word (CR4) and the address-line-20 gate mask. It also keeps a small set of hidden mode flags derived from those registers. Each register has its own write strobe and data bus. On a write the block forces the bits that must always be set and clears bits that the core's capabilities do not allow. The stored values and the derived flags are driven continuously onto output ports for the rest of the core.

The unit also decides when cached translations have gone stale and asks the TLB to flush them. A change to a paging-relevant bit asks for a full flush. A page-table base reload while paging is on asks for a flush of non-global entries only. Writes to several registers in one cycle are applied in a fixed order, CR0 first, then CR3, then CR4, then the A20 gate. A later write sees the result of an earlier one. Every request comes out as a one-cycle registered pulse.

Top module: `pgctl_unit`

## Requirements
- R1: After synchronous reset: CR0 reads 0x60000010, CR3 and CR4 read 0, the A20 mask reads 0xFFFFFFFF, the protected flag is 0, the segment-add flag is 1, the MP/EM/TS and OSFXSR flags are 0, and both flush outputs are 0.
- R2: A CR0 write stores the written value with bit 4 (ET) forced to 1. A register that is not written keeps its value.
- R3: A CR0 write requests a full flush exactly when bit 31 (PG), bit 16 (WP) or bit 0 (PE) of the new value differs from the stored value.
- R4: After a CR0 write the protected flag equals the new bit 0, and the segment-add flag is set when bit 0 is 0 and cleared when it is 1.
- R5: After a CR0 write the MP, EM and TS flags equal the new CR0 bits 1, 2 and 3.
- R6: A CR3 write stores the full value. It requests a non-global flush only when CR0 bit 31 is 1.
- R7: A CR4 write requests a full flush exactly when bit 4 (PSE), bit 5 (PAE) or bit 7 (PGE) changes.
- R8: A CR4 write stores bit 9 (OSFXSR) as 0 when `sse_cap` is 0. The OSFXSR flag always equals stored CR4 bit 9.
- R9: An A20 write whose gate differs from mask bit 20 sets the mask to 0xFFEFFFFF with bit 20 equal to the gate, and requests a full flush. A write of the same gate changes nothing and requests nothing.
- R10: Flush outputs are registered. They are high during the single cycle that follows the write edge. When a full flush and a non-global flush are requested together, only `flush_all` is raised.
- R11: When CR0 and CR3 are written in the same cycle, the CR3 flush decision uses the PG bit of the newly written CR0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr0_wr | input | 1 | CR0 write strobe |
| cr0_wdata | input | 32 | CR0 write value |
| cr3_wr | input | 1 | CR3 write strobe |
| cr3_wdata | input | 32 | CR3 write value |
| cr4_wr | input | 1 | CR4 write strobe |
| cr4_wdata | input | 32 | CR4 write value |
| sse_cap | input | 1 | Core supports the SSE state; 0 blocks CR4 bit 9 |
| a20_wr | input | 1 | A20 gate write strobe |
| a20_gate | input | 1 | Requested A20 gate state |
| cr0_q | output | 32 | Stored CR0 |
| cr3_q | output | 32 | Stored CR3 |
| cr4_q | output | 32 | Stored CR4 |
| a20_mask | output | 32 | Physical address mask |
| pe_flag | output | 1 | Protected-mode flag |
| addseg_flag | output | 1 | Segment-base add flag |
| mp_flag | output | 1 | Monitor-coprocessor flag |
| em_flag | output | 1 | FPU-emulation flag |
| ts_flag | output | 1 | Task-switched flag |
| osfxsr_flag | output | 1 | Extended FPU save enabled flag |
| flush_all | output | 1 | One-cycle full TLB flush request |
| flush_nonglobal | output | 1 | One-cycle non-global TLB flush request |

## Verification
The assertions assume that every strobe is a clean 0 or 1 at each rising edge. They also assume that the write data are stable across the edge, so each `$past` of a strobe or data bus names exactly the write that was applied. The bench drives all inputs at the falling edge, drops the strobes right after the rising edge it targets, and never leaves an X on any input once reset is released. That keeps every edge inside this assumption. Reset is asserted again in the middle of the run, and the checks on the cycle after it rely on the flush registers and the hidden flags taking their reset values in the same edge as the control registers.

// File: rtl/pgctl_pkg.sv
package pgctl_pkg;

    localparam int CR_W = 32;

    // CR0 bit positions
    localparam int CR0_PE = 0;
    localparam int CR0_MP = 1;
    localparam int CR0_EM = 2;
    localparam int CR0_TS = 3;
    localparam int CR0_ET = 4;
    localparam int CR0_WP = 16;
    localparam int CR0_PG = 31;

    // CR4 bit positions
    localparam int CR4_PSE    = 4;
    localparam int CR4_PAE    = 5;
    localparam int CR4_PGE    = 7;
    localparam int CR4_OSFXSR = 9;

    localparam int A20_POS = 20;

    localparam logic [CR_W-1:0] CR0_RST = 32'h6000_0010;
    localparam logic [CR_W-1:0] CR0_FLUSH_MASK =
        (CR_W'(1) << CR0_PG) | (CR_W'(1) << CR0_WP) | (CR_W'(1) << CR0_PE);
    localparam logic [CR_W-1:0] CR4_FLUSH_MASK =
        (CR_W'(1) << CR4_PGE) | (CR_W'(1) << CR4_PAE) | (CR_W'(1) << CR4_PSE);

    typedef struct packed {
        logic pe;
        logic addseg;
        logic mp;
        logic em;
        logic ts;
    } hflags_t;

    function automatic logic [CR_W-1:0] cr0_force(input logic [CR_W-1:0] v);
        logic [CR_W-1:0] r;
        r = v;
        r[CR0_ET] = 1'b1;
        return r;
    endfunction

    function automatic hflags_t hflags_of(input logic [CR_W-1:0] c0);
        hflags_t h;
        h.pe     = c0[CR0_PE];
        h.addseg = ~c0[CR0_PE];
        h.mp     = c0[CR0_MP];
        h.em     = c0[CR0_EM];
        h.ts     = c0[CR0_TS];
        return h;
    endfunction

    function automatic logic [CR_W-1:0] cr4_filter(input logic [CR_W-1:0] v,
                                                   input logic sse);
        logic [CR_W-1:0] r;
        r = v;
        if (!sse) r[CR4_OSFXSR] = 1'b0;
        return r;
    endfunction

    function automatic logic [CR_W-1:0] a20_mask_of(input logic gate, input int pos);
        logic [CR_W-1:0] r;
        r = '1;
        r[pos] = gate;
        return r;
    endfunction

endpackage

// File: rtl/pgctl_cr0.sv
module pgctl_cr0
    import pgctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [CR_W-1:0] wdata,
    output logic [CR_W-1:0] cr0_q,
    output hflags_t         hf_q,
    output logic            flush_req,
    output logic            pg_eff
);
    logic [CR_W-1:0] cr0_new;
    logic [CR_W-1:0] diff;

    assign cr0_new   = cr0_force(wdata);
    assign diff      = (cr0_new ^ cr0_q) & CR0_FLUSH_MASK;
    assign flush_req = wr && (diff != '0);
    // PG as seen by later writes in the same cycle
    assign pg_eff    = wr ? cr0_new[CR0_PG] : cr0_q[CR0_PG];

    always_ff @(posedge clk) begin
        if (rst) begin
            cr0_q <= CR0_RST;
            hf_q  <= hflags_of(CR0_RST);
        end else if (wr) begin
            cr0_q <= cr0_new;
            hf_q  <= hflags_of(cr0_new);
        end
    end

    AST_ET_HELD: assert property (@(posedge clk) disable iff (rst)
        wr |=> cr0_q[CR0_ET] && (cr0_q[CR_W-1:CR0_ET+1] == $past(wdata[CR_W-1:CR0_ET+1]))); // R2
    AST_CR0_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(cr0_q)); // R2
    AST_PE_ADDSEG: assert property (@(posedge clk) disable iff (rst)
        wr |=> (hf_q.pe == $past(wdata[CR0_PE])) && (hf_q.addseg != hf_q.pe)); // R4
    AST_FPU_FLAGS: assert property (@(posedge clk) disable iff (rst)
        wr |=> {hf_q.ts, hf_q.em, hf_q.mp} == $past(wdata[CR0_TS:CR0_MP])); // R5

endmodule

// File: rtl/pgctl_cr4.sv
module pgctl_cr4
    import pgctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [CR_W-1:0] wdata,
    input  logic            sse_cap,
    output logic [CR_W-1:0] cr4_q,
    output logic            osfxsr_q,
    output logic            flush_req
);
    logic [CR_W-1:0] cr4_new;

    assign cr4_new   = cr4_filter(wdata, sse_cap);
    assign flush_req = wr && (((cr4_new ^ cr4_q) & CR4_FLUSH_MASK) != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cr4_q    <= '0;
            osfxsr_q <= 1'b0;
        end else if (wr) begin
            cr4_q    <= cr4_new;
            osfxsr_q <= cr4_new[CR4_OSFXSR];
        end
    end

    AST_OSFXSR_GATED: assert property (@(posedge clk) disable iff (rst)
        (wr && !sse_cap) |=> !cr4_q[CR4_OSFXSR] && !osfxsr_q); // R8
    AST_OSFXSR_PASS: assert property (@(posedge clk) disable iff (rst)
        (wr && sse_cap) |=> osfxsr_q == $past(wdata[CR4_OSFXSR])); // R8
    AST_CR4_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(cr4_q) && $stable(osfxsr_q)); // R8

endmodule

// File: rtl/pgctl_a20.sv
module pgctl_a20
    import pgctl_pkg::*;
#(
    parameter int GATE_POS = A20_POS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic            gate,
    output logic [CR_W-1:0] mask_q,
    output logic            flush_req
);
    localparam logic [CR_W-1:0] OTHER_BITS = ~(CR_W'(1) << GATE_POS);

    logic change;

    assign change    = wr && (gate != mask_q[GATE_POS]);
    assign flush_req = change;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (change) begin
            mask_q <= a20_mask_of(gate, GATE_POS);
        end
    end

    AST_A20_SAME: assert property (@(posedge clk) disable iff (rst)
        (wr && (gate == mask_q[GATE_POS])) |=> $stable(mask_q)); // R9
    AST_A20_OTHERS: assert property (@(posedge clk) disable iff (rst)
        (mask_q & OTHER_BITS) == OTHER_BITS); // R9
    AST_A20_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        wr |=> mask_q[GATE_POS] == $past(gate)); // R9

endmodule

// File: rtl/pgctl_flush.sv
module pgctl_flush #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] glob_req,
    input  logic            ng_req,
    output logic            flush_all,
    output logic            flush_ng
);
    logic any_glob;

    assign any_glob = |glob_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_all <= 1'b0;
            flush_ng  <= 1'b0;
        end else begin
            flush_all <= any_glob;
            flush_ng  <= ng_req && !any_glob;
        end
    end

    AST_FLUSH_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(flush_all && flush_ng)); // R10
    AST_ALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (flush_all && !$past(rst)) |-> $past(any_glob)); // R10
    AST_NG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (flush_ng && !$past(rst)) |-> $past(ng_req)); // R6

endmodule

// File: rtl/pgctl_unit.sv
module pgctl_unit
    import pgctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cr0_wr,
    input  logic [CR_W-1:0] cr0_wdata,
    input  logic            cr3_wr,
    input  logic [CR_W-1:0] cr3_wdata,
    input  logic            cr4_wr,
    input  logic [CR_W-1:0] cr4_wdata,
    input  logic            sse_cap,
    input  logic            a20_wr,
    input  logic            a20_gate,
    output logic [CR_W-1:0] cr0_q,
    output logic [CR_W-1:0] cr3_q,
    output logic [CR_W-1:0] cr4_q,
    output logic [CR_W-1:0] a20_mask,
    output logic            pe_flag,
    output logic            addseg_flag,
    output logic            mp_flag,
    output logic            em_flag,
    output logic            ts_flag,
    output logic            osfxsr_flag,
    output logic            flush_all,
    output logic            flush_nonglobal
);
    localparam int NGLOB = 3;

    hflags_t         hf;
    logic            cr0_flush, cr4_flush, a20_flush;
    logic            pg_eff;
    logic            cr3_flush;
    logic [NGLOB-1:0] glob_req;

    pgctl_cr0 u_cr0 (
        .clk       (clk),
        .rst       (rst),
        .wr        (cr0_wr),
        .wdata     (cr0_wdata),
        .cr0_q     (cr0_q),
        .hf_q      (hf),
        .flush_req (cr0_flush),
        .pg_eff    (pg_eff)
    );

    // CR3: plain storage; flush decision uses PG after any same-cycle CR0 write
    always_ff @(posedge clk) begin
        if (rst)         cr3_q <= '0;
        else if (cr3_wr) cr3_q <= cr3_wdata;
    end
    assign cr3_flush = cr3_wr && pg_eff;

    pgctl_cr4 u_cr4 (
        .clk       (clk),
        .rst       (rst),
        .wr        (cr4_wr),
        .wdata     (cr4_wdata),
        .sse_cap   (sse_cap),
        .cr4_q     (cr4_q),
        .osfxsr_q  (osfxsr_flag),
        .flush_req (cr4_flush)
    );

    pgctl_a20 #(.GATE_POS(A20_POS)) u_a20 (
        .clk       (clk),
        .rst       (rst),
        .wr        (a20_wr),
        .gate      (a20_gate),
        .mask_q    (a20_mask),
        .flush_req (a20_flush)
    );

    assign glob_req = {a20_flush, cr4_flush, cr0_flush};

    pgctl_flush #(.NSRC(NGLOB)) u_flush (
        .clk       (clk),
        .rst       (rst),
        .glob_req  (glob_req),
        .ng_req    (cr3_flush),
        .flush_all (flush_all),
        .flush_ng  (flush_nonglobal)
    );

    assign pe_flag     = hf.pe;
    assign addseg_flag = hf.addseg;
    assign mp_flag     = hf.mp;
    assign em_flag     = hf.em;
    assign ts_flag     = hf.ts;

    AST_CR3_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cr3_wr |=> $stable(cr3_q)); // R6
    AST_NG_NEEDS_PG: assert property (@(posedge clk) disable iff (rst)
        flush_nonglobal |-> cr0_q[CR0_PG]); // R11
    AST_PE_MATCH: assert property (@(posedge clk) disable iff (rst)
        pe_flag == cr0_q[CR0_PE]); // R4

endmodule

// File: tb/sim_pgctl_unit.sv
`timescale 1ns/100ps
module sim_pgctl_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        cr0_wr, cr3_wr, cr4_wr, a20_wr, sse_cap, a20_gate;
    logic [31:0] cr0_wdata, cr3_wdata, cr4_wdata;
    logic [31:0] cr0_q, cr3_q, cr4_q, a20_mask;
    logic        pe_flag, addseg_flag, mp_flag, em_flag, ts_flag, osfxsr_flag;
    logic        flush_all, flush_nonglobal;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // expected state
    logic [31:0] e_cr0, e_cr3, e_cr4, e_mask;
    logic        e_pe, e_as, e_mp, e_em, e_ts, e_osf, e_fa, e_fn;

    always #2.5 clk = ~clk;

    pgctl_unit u0 (
        .clk(clk), .rst(rst),
        .cr0_wr(cr0_wr), .cr0_wdata(cr0_wdata),
        .cr3_wr(cr3_wr), .cr3_wdata(cr3_wdata),
        .cr4_wr(cr4_wr), .cr4_wdata(cr4_wdata),
        .sse_cap(sse_cap), .a20_wr(a20_wr), .a20_gate(a20_gate),
        .cr0_q(cr0_q), .cr3_q(cr3_q), .cr4_q(cr4_q), .a20_mask(a20_mask),
        .pe_flag(pe_flag), .addseg_flag(addseg_flag), .mp_flag(mp_flag),
        .em_flag(em_flag), .ts_flag(ts_flag), .osfxsr_flag(osfxsr_flag),
        .flush_all(flush_all), .flush_nonglobal(flush_nonglobal)
    );

    task automatic chk(input string ctx, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%08h expected=%08h", tag, ctx, act, exp);
        end
    endtask

    task automatic model_reset();
        e_cr0 = 32'h6000_0010; e_cr3 = '0; e_cr4 = '0; e_mask = 32'hFFFF_FFFF;
        e_pe = 0; e_as = 1; e_mp = 0; e_em = 0; e_ts = 0; e_osf = 0;
        e_fa = 0; e_fn = 0;
    endtask

    task automatic check_all(input string ctx);
        chk(ctx, "R2 cr0", cr0_q, e_cr0);
        chk(ctx, "R6 cr3", cr3_q, e_cr3);
        chk(ctx, "R8 cr4", cr4_q, e_cr4);
        chk(ctx, "R9 mask", a20_mask, e_mask);
        chk(ctx, "R4 pe/addseg", {30'd0, pe_flag, addseg_flag}, {30'd0, e_pe, e_as});
        chk(ctx, "R5 mp/em/ts", {29'd0, ts_flag, em_flag, mp_flag}, {29'd0, e_ts, e_em, e_mp});
        chk(ctx, "R8 osfxsr", {31'd0, osfxsr_flag}, {31'd0, e_osf});
        chk(ctx, "R10 flush_all", {31'd0, flush_all}, {31'd0, e_fa});
        chk(ctx, "R6 flush_nonglobal", {31'd0, flush_nonglobal}, {31'd0, e_fn});
    endtask

    task automatic vec(input string ctx,
                       input logic w0, input logic [31:0] d0,
                       input logic w3, input logic [31:0] d3,
                       input logic w4, input logic [31:0] d4, input logic sse,
                       input logic wa, input logic ga);
        logic [31:0] n;
        @(negedge clk);
        cr0_wr = w0; cr0_wdata = d0; cr3_wr = w3; cr3_wdata = d3;
        cr4_wr = w4; cr4_wdata = d4; sse_cap = sse; a20_wr = wa; a20_gate = ga;
        e_fa = 0; e_fn = 0;
        if (w0) begin
            n = d0 | 32'h10;
            if (((n ^ e_cr0) & 32'h8001_0001) != 0) e_fa = 1;
            e_cr0 = n; e_pe = n[0]; e_as = !n[0];
            e_mp = n[1]; e_em = n[2]; e_ts = n[3];
        end
        if (w3) begin
            e_cr3 = d3;
            if (e_cr0[31]) e_fn = 1;
        end
        if (w4) begin
            n = d4;
            if (!sse) n[9] = 1'b0;
            if (((n ^ e_cr4) & 32'h0000_00B0) != 0) e_fa = 1;
            e_cr4 = n; e_osf = n[9];
        end
        if (wa && (ga != e_mask[20])) begin
            e_mask = 32'hFFEF_FFFF | ({31'd0, ga} << 20);
            e_fa = 1;
        end
        if (e_fa) e_fn = 0;
        @(posedge clk);
        #1;
        cr0_wr = 0; cr3_wr = 0; cr4_wr = 0; a20_wr = 0;
        check_all(ctx);
    endtask

    task automatic idle(input string ctx);
        vec(ctx, 0, 32'hDEAD_BEEF, 0, 32'h1234_5678, 0, 32'hFFFF_FFFF, 1, 0, 0);
    endtask

    function automatic logic [31:0] cr0_pat(input int i);
        logic [31:0] sel, fill;
        sel = '0;
        sel[0] = i[0]; sel[1] = i[1]; sel[2] = i[2]; sel[3] = i[3];
        sel[4] = i[4]; sel[16] = i[5]; sel[31] = i[6];
        fill = (32'(i) * 32'h9E37_79B9) & ~32'h8001_001F;
        return sel | fill;
    endfunction

    initial begin
        #(5.0 * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1; cr0_wr = 0; cr3_wr = 0; cr4_wr = 0; a20_wr = 0;
        cr0_wdata = '0; cr3_wdata = '0; cr4_wdata = '0; sse_cap = 1; a20_gate = 1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        check_all("R1 reset state");
        idle("R10 idle after reset");

        // CR0 sweep over PE/MP/EM/TS/ET/WP/PG, each followed by CR3 reload (R3 R4 R5 R6)
        for (int i = 0; i < 128; i++) begin
            vec("R3 cr0 sweep", 1, cr0_pat(i), 0, 0, 0, 0, 1, 0, 0);
            vec("R6 cr3 reload", 0, 0, 1, 32'(i) * 32'h0101_1000 + 32'h123, 0, 0, 1, 0, 0);
        end
        idle("R10 pulse drops");

        // CR4 sweep over PSE/PAE/PGE/OSFXSR with both capability values (R7 R8)
        for (int s = 0; s < 2; s++) begin
            for (int j = 0; j < 16; j++) begin
                logic [31:0] d;
                d = 32'h0000_0408 ^ (32'(j) << 14);
                d[4] = j[0]; d[5] = j[1]; d[7] = j[2]; d[9] = j[3];
                vec("R7 cr4 sweep", 0, 0, 0, 0, 1, d, s[0], 0, 0);
            end
        end
        idle("R10 idle");

        // A20 gate sequence including same-state writes (R9)
        vec("R9 a20 same 1",   0, 0, 0, 0, 0, 0, 1, 1, 1);
        vec("R9 a20 to 0",     0, 0, 0, 0, 0, 0, 1, 1, 0);
        vec("R9 a20 same 0",   0, 0, 0, 0, 0, 0, 1, 1, 0);
        vec("R9 a20 to 1",     0, 0, 0, 0, 0, 0, 1, 1, 1);
        vec("R9 a20 to 0 b",   0, 0, 0, 0, 0, 0, 1, 1, 0);
        idle("R10 idle");

        // Same-cycle ordering (R11): CR0 turns PG on with no flush-bit change elsewhere
        vec("R11 pg off",      1, 32'h0000_0001, 0, 0, 0, 0, 1, 0, 0);
        vec("R11 pg on + cr3", 1, 32'h8000_0001, 1, 32'h0000_5000, 0, 0, 1, 0, 0);
        vec("R11 pg same + cr3", 1, 32'h8000_000F, 1, 32'h0000_6000, 0, 0, 1, 0, 0);
        vec("R11 pg drop + cr3", 1, 32'h0000_0001, 1, 32'h0000_7000, 0, 0, 1, 0, 0);
        vec("R11 cr3 paging off", 0, 0, 1, 32'h0000_8000, 0, 0, 1, 0, 0);
        vec("R11 pg on again", 1, 32'h8000_0001, 0, 0, 0, 0, 1, 0, 0);
        // R10: global and non-global together, only global raised
        vec("R10 cr3+cr4 change", 0, 0, 1, 32'h0000_9000, 1, 32'h0000_0020, 1, 0, 0);
        vec("R10 cr3+a20 change", 0, 0, 1, 32'h0000_A000, 0, 0, 1, 1, 1);
        vec("R10 all four", 1, 32'h8001_0001, 1, 32'h0000_B000, 1, 32'h0000_02B0, 0, 1, 0);
        idle("R10 pulse one cycle");

        // reset in the middle of the run (R1)
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        model_reset();
        check_all("R1 second reset");
        idle("R1 after reset idle");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule